// File: doc/BRIEF.md
# Rolling Shutter Row Sequencer

This block paces the row operations of a row-addressed image sensor that uses an electronic rolling shutter. It walks two row pointers down a programmed window of interest. The clear pointer empties a row and starts its integration. The sample pointer selects the same row for readout a fixed number of row slots later. Each pointer advances by one row per row slot, and a slot lasts a programmed number of clock cycles. Successive rows therefore start and end their exposure one slot apart, which gives the skewed top-to-bottom exposure of a rolling shutter.

The exposure is given in rows, which means in slots. With a frame accumulation count of two or more, a row integrates over that many frame intervals instead. A smaller window shortens the frame interval in proportion, so frames come out faster. The block samples its configuration when `run` rises and holds it until `run` falls. When `run` falls, the block stops at the next clock edge.

Top module: `rs_row_sequencer`

## Requirements
- R1: A row slot lasts `rrt_cycles` clock cycles, and a value of 0 counts as 1. The first slot begins on the second rising edge at which `run` is high. Strobes can rise only on the first cycle of a slot, and each strobe stays high for exactly one cycle.
- R2: Let H be the window height and P the frame period in slots. In slot s, with p = s mod P, `clr_stb` rises with `clr_row` = first + p whenever p < H. No clear strobe is issued in any other slot.
- R3: The sample pointer starts X slots after the clear pointer, where X is the effective exposure. In slot s ≥ X, with q = (s − X) mod P, `smp_stb` rises with `smp_row` = first + q whenever q < H. Each row is therefore sampled exactly X slots after it is cleared.
- R4: `frame_start` is high only together with the clear strobe of the first window row.
- R5: `frame_done` is high only together with the sample strobe of the last window row.
- R6: Each window bound is clamped to NUM_ROWS − 1. If the last row is below the first row, the window is the first row alone.
- R7: An exposure of 0 counts as 1 row. An exposure above EXP_MAX counts as EXP_MAX.
- R8: The frame period P is the larger of H and X. A long exposure therefore stretches the period, and the next frame's clears overlap the current frame's samples without clearing any row that has not been sampled.
- R9: With an accumulation count of 2 or more, X equals the count times H and `exp_rows` is ignored. A count of 0 or 1 selects the normal exposure.
- R10: Changes to the configuration inputs while `run` is high have no effect on the output sequence. When `run` is low at a rising edge, no strobe is high after that edge.
- R11: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | High to run the sequence; the rise samples the configuration |
| rrt_cycles | input | RRT_W | Clock cycles per row slot |
| exp_rows | input | EXP_W | Exposure in row slots |
| win_first | input | ROW_W | First row of the window |
| win_last | input | ROW_W | Last row of the window |
| acc_frames | input | ACC_W | Frame accumulation count |
| clr_stb | output | 1 | Clear strobe for a row |
| clr_row | output | ROW_W | Row being cleared |
| smp_stb | output | 1 | Sample (readout select) strobe for a row |
| smp_row | output | ROW_W | Row being sampled |
| frame_start | output | 1 | Clear of the first window row |
| frame_done | output | 1 | Sample of the last window row |

## Verification
The bench targets the boundary between exposures shorter than, equal to and longer than the window height. If the period were taken as H alone, a row would be cleared again before its sample and the row sequence would break. It also covers zero and oversized exposure, zero slot length, and reversed or oversized window bounds. A design that handled any of these wrong would shift the sample pointer or walk rows outside the window. Accumulation runs confirm that the exposure becomes the count times the window height. A change to the configuration during a run, followed by a stop, confirms that the latched settings hold and that strobes cease on the next edge.

// File: rtl/rs_seq_pkg.sv
// Shared defaults and helpers for the rolling shutter row sequencer.
package rs_seq_pkg;
    localparam int unsigned RS_ROW_W    = 8;
    localparam int unsigned RS_NUM_ROWS = 200;
    localparam int unsigned RS_EXP_W    = 10;
    localparam int unsigned RS_EXP_MAX  = 600;
    localparam int unsigned RS_ACC_W    = 4;
    localparam int unsigned RS_RRT_W    = 8;

    // Larger of two widths, used to size the period datapath.
    function automatic int unsigned rs_umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/rs_seq_cfg.sv
// Effective configuration: clamps the raw settings and derives the window
// height, exposure slots, frame period and slot length. Purely combinational.
// Assumes NUM_ROWS <= 2**ROW_W and EXP_MAX < 2**EXP_W.
module rs_seq_cfg #(
    parameter int unsigned ROW_W    = 8,
    parameter int unsigned NUM_ROWS = 200,
    parameter int unsigned EXP_W    = 10,
    parameter int unsigned EXP_MAX  = 600,
    parameter int unsigned ACC_W    = 4,
    parameter int unsigned RRT_W    = 8,
    parameter int unsigned PER_W    = 13
) (
    input  logic [RRT_W-1:0] rrt_in,
    input  logic [EXP_W-1:0] exp_in,
    input  logic [ROW_W-1:0] first_in,
    input  logic [ROW_W-1:0] last_in,
    input  logic [ACC_W-1:0] acc_in,
    output logic [ROW_W-1:0] base_o,
    output logic [ROW_W:0]   height_o,
    output logic [PER_W-1:0] expo_o,
    output logic [PER_W-1:0] period_o,
    output logic [RRT_W-1:0] rrt_o
);
    localparam logic [ROW_W-1:0] TOP_ROW = ROW_W'(NUM_ROWS - 1);
    localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(EXP_MAX);

    logic [ROW_W-1:0] first_c, last_c, last_fix;
    logic [EXP_W-1:0] exp_c;
    logic [PER_W-1:0] height_w, acc_prod;

    // Clamp window bounds and exposure, then derive the exposure and period.
    always_comb begin
        first_c  = (first_in > TOP_ROW) ? TOP_ROW : first_in;
        last_c   = (last_in > TOP_ROW) ? TOP_ROW : last_in;
        last_fix = (last_c < first_c) ? first_c : last_c;
        height_o = {1'b0, last_fix} - {1'b0, first_c} + 1'b1;
        base_o   = first_c;
        exp_c    = (exp_in == '0) ? EXP_W'(1) : ((exp_in > EXP_CAP) ? EXP_CAP : exp_in);
        height_w = PER_W'(height_o);
        acc_prod = PER_W'(acc_in) * height_w;
        expo_o   = (acc_in > ACC_W'(1)) ? acc_prod : PER_W'(exp_c);
        period_o = (expo_o > height_w) ? expo_o : height_w;
        rrt_o    = (rrt_in == '0) ? RRT_W'(1) : rrt_in;
    end
endmodule

// File: rtl/rs_slot_timer.sv
// Row slot timer: divides the clock into slots of rrt cycles and flags the
// first cycle of every slot. Assumes rrt >= 1 and stable while en is high.
module rs_slot_timer #(
    parameter int unsigned RRT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [RRT_W-1:0] rrt,
    output logic             tick
);
    logic [RRT_W-1:0] tcnt;

    // Count cycles within the slot, restarting from zero when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)       tcnt <= '0;
        else if (tcnt == rrt - 1'b1) tcnt <= '0;
        else                     tcnt <= tcnt + 1'b1;
    end

    assign tick = en && (tcnt == '0);

    // R1: slot starts are at least two cycles apart unless a slot is one cycle long.
    a_r1_slot_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rrt != RRT_W'(1)) |=> !tick);
endmodule

// File: rtl/rs_row_pointer.sv
// One row pointer: waits a programmed number of slots, then steps one row per
// slot through a period of `period` slots, the first `height` of which address
// window rows. Outputs are registered single-cycle strobes with the row address.
// Assumes base, height and period are stable while tick can occur.
module rs_row_pointer #(
    parameter int unsigned ROW_W = 8,
    parameter int unsigned PER_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PER_W-1:0] load_delay,
    input  logic             tick,
    input  logic [ROW_W-1:0] base,
    input  logic [ROW_W:0]   height,
    input  logic [PER_W-1:0] period,
    output logic             stb,
    output logic [ROW_W-1:0] row,
    output logic             first_row,
    output logic             last_row
);
    logic [PER_W-1:0] dly;
    logic [PER_W-1:0] phase;
    logic [PER_W-1:0] height_w;
    logic             hit;

    assign height_w = PER_W'(height);
    assign hit      = tick && (dly == '0) && (phase < height_w);

    // Track the start delay and the position inside the frame period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly   <= '0;
            phase <= '0;
        end else if (load) begin
            dly   <= load_delay;
            phase <= '0;
        end else if (tick) begin
            if (dly != '0)                  dly   <= dly - 1'b1;
            else if (phase == period - 1'b1) phase <= '0;
            else                            phase <= phase + 1'b1;
        end
    end

    // Register the strobe, the row address and the frame-edge flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb       <= 1'b0;
            row       <= '0;
            first_row <= 1'b0;
            last_row  <= 1'b0;
        end else begin
            stb       <= hit;
            row       <= hit ? (base + phase[ROW_W-1:0]) : '0;
            first_row <= hit && (phase == '0);
            last_row  <= hit && (phase == height_w - 1'b1);
        end
    end

    // R2/R3: every addressed row lies inside the window.
    a_r2_row_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> (row >= base) && ({1'b0, row} <= {1'b0, base} + height - 1'b1));
    // R8: the position never leaves the frame period.
    a_r8_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (period != '0) |-> (phase < period));
endmodule

// File: rtl/rs_row_sequencer.sv
// Rolling shutter row sequencer top. Samples the configuration when run rises,
// then drives a clear pointer and a sample pointer that lags it by the
// effective exposure, both paced by the row slot timer. Stops on run low.
// Assumes the window rows exist on the sensor after clamping to NUM_ROWS.
module rs_row_sequencer
    import rs_seq_pkg::*;
#(
    parameter int unsigned ROW_W    = RS_ROW_W,
    parameter int unsigned NUM_ROWS = RS_NUM_ROWS,
    parameter int unsigned EXP_W    = RS_EXP_W,
    parameter int unsigned EXP_MAX  = RS_EXP_MAX,
    parameter int unsigned ACC_W    = RS_ACC_W,
    parameter int unsigned RRT_W    = RS_RRT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [RRT_W-1:0] rrt_cycles,
    input  logic [EXP_W-1:0] exp_rows,
    input  logic [ROW_W-1:0] win_first,
    input  logic [ROW_W-1:0] win_last,
    input  logic [ACC_W-1:0] acc_frames,
    output logic             clr_stb,
    output logic [ROW_W-1:0] clr_row,
    output logic             smp_stb,
    output logic [ROW_W-1:0] smp_row,
    output logic             frame_start,
    output logic             frame_done
);
    localparam int unsigned PER_W = rs_umax(EXP_W, ACC_W + ROW_W + 1) + 1;

    logic             active, load, slot_en, tick;
    logic [ROW_W-1:0] base_n, base_q;
    logic [ROW_W:0]   height_n, height_q;
    logic [PER_W-1:0] expo_n, period_n, period_q;
    logic [RRT_W-1:0] rrt_n, rrt_q;

    rs_seq_cfg #(
        .ROW_W(ROW_W), .NUM_ROWS(NUM_ROWS), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX),
        .ACC_W(ACC_W), .RRT_W(RRT_W), .PER_W(PER_W)
    ) u_cfg (
        .rrt_in(rrt_cycles), .exp_in(exp_rows), .first_in(win_first),
        .last_in(win_last), .acc_in(acc_frames), .base_o(base_n),
        .height_o(height_n), .expo_o(expo_n), .period_o(period_n), .rrt_o(rrt_n)
    );

    assign load    = run && !active;
    assign slot_en = run && active;

    // Follow run one cycle late so its rise marks the configuration load.
    always_ff @(posedge clk) begin
        if (!rst_n) active <= 1'b0;
        else        active <= run;
    end

    // Hold the effective configuration for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            height_q <= (ROW_W+1)'(1);
            period_q <= PER_W'(1);
            rrt_q    <= RRT_W'(1);
        end else if (load) begin
            base_q   <= base_n;
            height_q <= height_n;
            period_q <= period_n;
            rrt_q    <= rrt_n;
        end
    end

    rs_slot_timer #(.RRT_W(RRT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(slot_en), .rrt(rrt_q), .tick(tick)
    );

    rs_row_pointer #(.ROW_W(ROW_W), .PER_W(PER_W)) u_clr_ptr (
        .clk(clk), .rst_n(rst_n), .load(load), .load_delay('0), .tick(tick),
        .base(base_q), .height(height_q), .period(period_q),
        .stb(clr_stb), .row(clr_row), .first_row(frame_start), .last_row()
    );

    rs_row_pointer #(.ROW_W(ROW_W), .PER_W(PER_W)) u_smp_ptr (
        .clk(clk), .rst_n(rst_n), .load(load), .load_delay(expo_n), .tick(tick),
        .base(base_q), .height(height_q), .period(period_q),
        .stb(smp_stb), .row(smp_row), .first_row(), .last_row(frame_done)
    );

    // R4: frame start accompanies the clear of the first window row.
    a_r4_start_on_first: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> clr_stb && (clr_row == base_q));
    // R5: frame done accompanies the sample of the last window row.
    a_r5_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> smp_stb && ({1'b0, smp_row} == {1'b0, base_q} + height_q - 1'b1));
    // R10: run low at an edge leaves no strobe after it.
    a_r10_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !clr_stb && !smp_stb);
    // R1: strobes last a single cycle when slots are longer than one cycle.
    a_r1_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && rrt_q != RRT_W'(1) && $stable(rrt_q)) |=> !smp_stb);
endmodule

// File: tb/rs_row_sequencer_tb.sv
module rs_row_sequencer_tb;
    localparam int NROWS = 200;
    localparam int EMAX  = 600;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [7:0] rrt_cycles = '0;
    logic [9:0] exp_rows = '0;
    logic [7:0] win_first = '0, win_last = '0;
    logic [3:0] acc_frames = '0;
    logic       clr_stb, smp_stb, frame_start, frame_done;
    logic [7:0] clr_row, smp_row;

    int vectors = 0;
    int errors  = 0;

    always #5 clk = ~clk;

    rs_row_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .rrt_cycles(rrt_cycles),
        .exp_rows(exp_rows), .win_first(win_first), .win_last(win_last),
        .acc_frames(acc_frames), .clr_stb(clr_stb), .clr_row(clr_row),
        .smp_stb(smp_stb), .smp_row(smp_row), .frame_start(frame_start),
        .frame_done(frame_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // Run one configuration and compare each cycle with the slot model.
    task automatic run_case(input int rrt, input int ex, input int f, input int l,
                            input int acc, input bit scramble);
        int fe, le, h, e, x, p, r, ncyc;
        fe = imin(f, NROWS - 1);
        le = imin(l, NROWS - 1);
        if (le < fe) le = fe;                       // R6
        h = le - fe + 1;
        e = (ex == 0) ? 1 : imin(ex, EMAX);         // R7
        x = (acc > 1) ? acc * h : e;                // R9
        p = (x > h) ? x : h;                        // R8
        r = (rrt == 0) ? 1 : rrt;                   // R1
        ncyc = imin(r * (x + 2 * p + 3), 3000);
        @(negedge clk);
        rrt_cycles = 8'(rrt); exp_rows = 10'(ex); win_first = 8'(f);
        win_last = 8'(l); acc_frames = 4'(acc); run = 1'b1;
        @(posedge clk);                             // configuration sampled here
        for (int n = 0; n < ncyc; n++) begin
            bit ec, es;
            int s, pc, q;
            @(posedge clk); #1;
            if (scramble && n == 0) begin           // R10: ignored mid-run
                rrt_cycles = 8'(rrt + 3); exp_rows = 10'(ex + 5);
                win_first = 8'(f + 1); win_last = 8'(l + 7); acc_frames = 4'(acc + 2);
            end
            ec = 0; es = 0; pc = 0; q = 0;
            if (n % r == 0) begin
                s  = n / r;
                pc = s % p;
                ec = (pc < h);
                if (s >= x) begin
                    q  = (s - x) % p;
                    es = (q < h);
                end
            end
            chk("R2", "clr_stb", int'(clr_stb), int'(ec));
            if (ec) chk("R2", "clr_row", int'(clr_row), fe + pc);
            chk("R3", "smp_stb", int'(smp_stb), int'(es));
            if (es) chk("R3", "smp_row", int'(smp_row), fe + q);
            chk("R4", "frame_start", int'(frame_start), int'(ec && pc == 0));
            chk("R5", "frame_done", int'(frame_done), int'(es && q == h - 1));
        end
        @(negedge clk);
        run = 1'b0;
        @(posedge clk); #1;
        chk("R10", "clr_stb after stop", int'(clr_stb), 0);
        chk("R10", "smp_stb after stop", int'(smp_stb), 0);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11", "clr_stb", int'(clr_stb), 0);
        chk("R11", "smp_stb", int'(smp_stb), 0);
        chk("R11", "frame_start", int'(frame_start), 0);
        chk("R11", "frame_done", int'(frame_done), 0);
        chk("R11", "rows", int'(clr_row) + int'(smp_row), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        run_case(3, 4, 10, 17, 1, 0);     // R2 R3: exposure shorter than window
        run_case(2, 12, 5, 9, 0, 0);      // R8: exposure longer than window
        run_case(1, 6, 20, 25, 1, 0);     // R8: exposure equal to window
        run_case(2, 0, 0, 3, 1, 0);       // R7: zero exposure is one row
        run_case(1, 1000, 50, 50, 0, 0);  // R7: exposure clamped to maximum
        run_case(2, 3, 30, 12, 1, 0);     // R6: reversed bounds
        run_case(1, 4, 190, 255, 1, 0);   // R6: bounds beyond the sensor
        run_case(2, 2, 0, 4, 3, 0);       // R9: accumulation of three frames
        run_case(0, 3, 7, 10, 1, 0);      // R1: zero slot length
        run_case(3, 5, 40, 45, 1, 1);     // R10: inputs changed while running
        for (int i = 0; i < 18; i++) begin
            int f;
            f = int'($urandom_range(0, 210));
            run_case(int'($urandom_range(0, 4)), int'($urandom_range(0, 30)), f,
                     f + int'($urandom_range(0, 12)), int'($urandom_range(0, 3)), 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule